// File: doc/BRIEF.md
# Dual Compare-Match Interval Timer

This block is an 8-bit up-counter that advances on a selectable count clock. The count clock is either one of six divided-clock enable strobes from a shared prescaler or an external pin, counted on its rising edge, its falling edge or both. Two compare registers are checked against the counter after every increment. A match raises a status flag and, if enabled, an interrupt request. It also moves a single waveform pin through a programmable action per channel.

The counter can be cleared by a match on either channel or by a rising edge on a reset pin. A clear parks the counter at zero and halts it. A selected edge on a trigger pin releases it again. This gives one-shot and externally gated interval generation without processor involvement. Software reaches the counter, the compare values, the two control words and the status word through a simple byte-wide read/write port.

Top module: `cmpTimer8`

## Requirements
- R1: After reset the registers read: counter (address 0) 0x00, compare A (address 1) 0xFF, compare B (address 2) 0xFF, control word 0 (address 3) 0x00, status (address 4) 0x10, control word 1 (address 5) 0xE2. The waveform pin and all interrupt outputs are 0. A write to address 0 loads the counter.
- R2: Internal clock selection uses clock field = control 0 bits [2:0] and extra select = control 1 bit 0. Field values 001, 010 and 011 count on prescaler strobe number (field-1)*2 + extra select; strobes that are not selected have no effect. Field 000 and field 111 stop the counter.
- R3: Field 100 counts rising edges of the external clock pin, 101 counts falling edges and 110 counts both edges. The pin is synchronized before use.
- R4: When an increment makes the counter equal compare A, status bit 6 is set. Equality with compare B sets status bit 7.
- R5: Interrupt output A is high while status bit 6 and control 0 bit 6 are both 1. Interrupt output B is high while status bit 7 and control 0 bit 7 are both 1.
- R6: On a match the waveform pin takes the action coded in status bits [1:0] for channel A and [3:2] for channel B: 00 hold, 01 drive 0, 10 drive 1, 11 toggle.
- R7: A count from 0xFF wraps to 0x00 and sets status bit 5. The overflow interrupt is high while status bit 5 and control 0 bit 5 are both 1.
- R8: A status flag is cleared only by writing 0 to it after it has been read as 1 since the previous status write. A write of 0 without that read leaves the flag set.
- R9: The clear mode is control 0 bits [4:3]: 00 never clears, 01 clears on match A, 10 clears on match B. A match clear happens on the next count clock, so the matching value stays readable for one count period.
- R10: After any clear the counter stays at zero and ignores count clocks until the trigger pin shows the edge coded in control 1 bits [4:3]: 01 rising, 10 falling, 11 either. Other edges do not restart it.
- R11: With clear mode 11, a synchronized rising edge on the reset pin clears the counter at once and halts it. With trigger code 00 no edge ever restarts it.
- R12: When both channels match on the same increment, channel B's pin action is applied and channel A's is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; arms flag clearing on status reads |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr |
| preTaps | input | 6 | Prescaler divided-clock enable strobes |
| extClkPin | input | 1 | External count clock |
| rstPin | input | 1 | Counter reset pin |
| trigPin | input | 1 | Restart trigger pin |
| outPin | output | 1 | Waveform output |
| irqCmpA | output | 1 | Compare A interrupt request |
| irqCmpB | output | 1 | Compare B interrupt request |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults: six prescaler strobes and two synchronizer stages. Six strobes let every internal selection code be reached, including the top strobe picked by the extra select bit. The bench drives the strobes one cycle at a time, so it knows the exact count at every read, and every match, wrap and halt can be placed on a known value. The two-stage synchronizer gives a short, fixed pin latency. Edge tests on the external clock, reset and trigger pins therefore settle within a few cycles of waiting.

// File: rtl/cmpTimerPkg.sv
package cmpTimerPkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL0 = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CTL1 = 3'd5;

  localparam logic [REG_W-1:0] CMP_RESET = '1;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_PIN  = 2'b11
  } clrModeT;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pinActT;

  typedef struct packed {
    logic    countTick;
    logic    hwClear;
    logic    restart;
    logic    swWrCnt;
    clrModeT clrMode;
  } strobeT;
endpackage

// File: rtl/cmpTimerDp.sv
module cmpTimerDp
  import cmpTimerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] cmpA,
  input  logic [REG_W-1:0] cmpB,
  output logic [REG_W-1:0] cntVal,
  output logic             matchAEv,
  output logic             matchBEv,
  output logic             ovfEv
);
  logic halted;
  logic pendClr;
  logic [REG_W-1:0] nxtCnt;

  assign nxtCnt = cntVal + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= '0;
      halted   <= 1'b0;
      pendClr  <= 1'b0;
      matchAEv <= 1'b0;
      matchBEv <= 1'b0;
      ovfEv    <= 1'b0;
    end else begin
      matchAEv <= 1'b0;
      matchBEv <= 1'b0;
      ovfEv    <= 1'b0;
      if (strb.restart) halted <= 1'b0;
      if (strb.swWrCnt) begin
        cntVal <= wdata;
      end else if (strb.hwClear) begin
        cntVal  <= '0;
        halted  <= 1'b1;
        pendClr <= 1'b0;
      end else if (strb.countTick && !halted) begin
        if (pendClr) begin
          cntVal  <= '0;
          halted  <= 1'b1;
          pendClr <= 1'b0;
        end else begin
          cntVal   <= nxtCnt;
          matchAEv <= (nxtCnt == cmpA);
          matchBEv <= (nxtCnt == cmpB);
          ovfEv    <= (cntVal == '1);
          pendClr  <= ((strb.clrMode == CLR_ON_A) && (nxtCnt == cmpA)) ||
                      ((strb.clrMode == CLR_ON_B) && (nxtCnt == cmpB));
        end
      end
    end
  end

  // R2: no count clock, no load, no clear -> counter holds
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countTick && !strb.swWrCnt && !strb.hwClear) |=> $stable(cntVal));

  // R7: wrap from all-ones
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countTick && !halted && !pendClr && !strb.swWrCnt && !strb.hwClear && cntVal == '1)
    |=> (ovfEv && cntVal == '0));

  // R9: pending match clear lands on the next count clock
  a_r9_deferred_clear: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr && strb.countTick && !halted && !strb.swWrCnt && !strb.hwClear)
    |=> (cntVal == '0 && halted));

  // R10: a halted counter does not move by itself
  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !strb.swWrCnt && !strb.hwClear) |=> $stable(cntVal));
endmodule

// File: rtl/cmpTimerCtrl.sv
module cmpTimerCtrl
  import cmpTimerPkg::*;
#(
  parameter int TAP_COUNT   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic [TAP_COUNT-1:0] preTaps,
  input  logic                 extClkPin,
  input  logic                 rstPin,
  input  logic                 trigPin,
  input  logic [REG_W-1:0]     cntVal,
  input  logic                 matchAEv,
  input  logic                 matchBEv,
  input  logic                 ovfEv,
  output logic [REG_W-1:0]     cmpA,
  output logic [REG_W-1:0]     cmpB,
  output strobeT               strb,
  output logic                 outPin,
  output logic                 irqCmpA,
  output logic                 irqCmpB,
  output logic                 irqOvf
);
  localparam int PIN_N   = 3;
  localparam int PIN_EXT = 0;
  localparam int PIN_RST = 1;
  localparam int PIN_TRG = 2;
  localparam int FLAG_N  = 3;  // index 0 ovf, 1 A, 2 B

  // pin synchronizers and edge detection
  logic [PIN_N-1:0] pinsIn, pinLvl, pinPrev, pinRise, pinFall;
  assign pinsIn = {trigPin, rstPin, extClkPin};

  for (genvar g = 0; g < PIN_N; g++) begin : gSync
    logic [SYNC_STAGES-1:0] syncQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinsIn[g]};
    end
    assign pinLvl[g] = syncQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinLvl;
  end
  assign pinRise = pinLvl & ~pinPrev;
  assign pinFall = ~pinLvl & pinPrev;

  // registers
  logic [2:0]        clkSel;
  logic              clkSelX;
  clrModeT           clrMode;
  logic              ieOvf, ieA, ieB;
  logic [1:0]        trigEdge;
  logic [3:0]        outSel;
  logic [FLAG_N-1:0] flags, armed, setEv;

  assign setEv = {matchBEv, matchAEv, ovfEv};

  logic wrCmpA, wrCmpB, wrCtl0, wrCtl1, wrStat, rdStat;
  assign wrCmpA = regWr && regAddr == ADDR_CMPA;
  assign wrCmpB = regWr && regAddr == ADDR_CMPB;
  assign wrCtl0 = regWr && regAddr == ADDR_CTL0;
  assign wrCtl1 = regWr && regAddr == ADDR_CTL1;
  assign wrStat = regWr && regAddr == ADDR_STAT;
  assign rdStat = regRd && regAddr == ADDR_STAT;

  logic [FLAG_N-1:0] wrFlagBits;
  assign wrFlagBits = regWdata[7:5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpA     <= CMP_RESET;
      cmpB     <= CMP_RESET;
      clkSel   <= '0;
      clkSelX  <= 1'b0;
      clrMode  <= CLR_NONE;
      ieOvf    <= 1'b0;
      ieA      <= 1'b0;
      ieB      <= 1'b0;
      trigEdge <= '0;
      outSel   <= '0;
    end else begin
      if (wrCmpA) cmpA <= regWdata;
      if (wrCmpB) cmpB <= regWdata;
      if (wrCtl0) begin
        ieB     <= regWdata[7];
        ieA     <= regWdata[6];
        ieOvf   <= regWdata[5];
        clrMode <= clrModeT'(regWdata[4:3]);
        clkSel  <= regWdata[2:0];
      end
      if (wrCtl1) begin
        trigEdge <= regWdata[4:3];
        clkSelX  <= regWdata[0];
      end
      if (wrStat) outSel <= regWdata[3:0];
    end
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[f] <= 1'b0;
        armed[f] <= 1'b0;
      end else begin
        if (setEv[f])                                   flags[f] <= 1'b1;
        else if (wrStat && !wrFlagBits[f] && armed[f])  flags[f] <= 1'b0;
        if (wrStat)                    armed[f] <= 1'b0;
        else if (rdStat && flags[f])   armed[f] <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CNT:  regRdata = cntVal;
      ADDR_CMPA: regRdata = cmpA;
      ADDR_CMPB: regRdata = cmpB;
      ADDR_CTL0: regRdata = {ieB, ieA, ieOvf, clrMode, clkSel};
      ADDR_STAT: regRdata = {flags, 1'b1, outSel};
      ADDR_CTL1: regRdata = {3'b111, trigEdge, 1'b0, 1'b1, clkSelX};
      default:   regRdata = '0;
    endcase
  end

  // count clock selection
  logic [2:0] tapIdx;
  logic       tapHit;
  logic       countTick;
  assign tapIdx = {clkSel[1:0] - 2'd1, clkSelX};
  assign tapHit = (int'(tapIdx) < TAP_COUNT) ? preTaps[tapIdx] : 1'b0;

  always_comb begin
    unique case (clkSel)
      3'd1, 3'd2, 3'd3: countTick = tapHit;
      3'd4:             countTick = pinRise[PIN_EXT];
      3'd5:             countTick = pinFall[PIN_EXT];
      3'd6:             countTick = pinRise[PIN_EXT] | pinFall[PIN_EXT];
      default:          countTick = 1'b0;
    endcase
  end

  logic restart;
  always_comb begin
    unique case (trigEdge)
      2'b01:   restart = pinRise[PIN_TRG];
      2'b10:   restart = pinFall[PIN_TRG];
      2'b11:   restart = pinRise[PIN_TRG] | pinFall[PIN_TRG];
      default: restart = 1'b0;
    endcase
  end

  assign strb.countTick = countTick;
  assign strb.hwClear   = (clrMode == CLR_PIN) && pinRise[PIN_RST];
  assign strb.restart   = restart;
  assign strb.swWrCnt   = regWr && regAddr == ADDR_CNT;
  assign strb.clrMode   = clrMode;

  // waveform pin
  function automatic logic applyAct(input logic cur, input logic [1:0] act);
    unique case (pinActT'(act))
      ACT_LOW:    applyAct = 1'b0;
      ACT_HIGH:   applyAct = 1'b1;
      ACT_TOGGLE: applyAct = ~cur;
      default:    applyAct = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outPin <= 1'b0;
    else if (matchBEv) outPin <= applyAct(outPin, outSel[3:2]);
    else if (matchAEv) outPin <= applyAct(outPin, outSel[1:0]);
  end

  assign irqOvf  = flags[0] & ieOvf;
  assign irqCmpA = flags[1] & ieA;
  assign irqCmpB = flags[2] & ieB;

  // R4: a match event always leaves its flag set
  a_r4_match_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    matchAEv |=> flags[1]);

  // R8: an unarmed status write never clears a set flag
  a_r8_unarmed_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (flags[1] && !armed[1]) |=> flags[1]);

  // R12: channel B action wins on a simultaneous match
  a_r12_b_priority: assert property (@(posedge clk) disable iff (!rstN)
    (matchAEv && matchBEv && outSel[3:2] == 2'b01) |=> !outPin);
endmodule

// File: rtl/cmpTimer8.sv
module cmpTimer8
  import cmpTimerPkg::*;
#(
  parameter int TAP_COUNT   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [7:0]           regWdata,
  output logic [7:0]           regRdata,
  input  logic [TAP_COUNT-1:0] preTaps,
  input  logic                 extClkPin,
  input  logic                 rstPin,
  input  logic                 trigPin,
  output logic                 outPin,
  output logic                 irqCmpA,
  output logic                 irqCmpB,
  output logic                 irqOvf
);
  strobeT           strb;
  logic [REG_W-1:0] cntVal, cmpA, cmpB;
  logic             matchAEv, matchBEv, ovfEv;

  cmpTimerCtrl #(.TAP_COUNT(TAP_COUNT), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .preTaps(preTaps), .extClkPin(extClkPin), .rstPin(rstPin), .trigPin(trigPin),
    .cntVal(cntVal), .matchAEv(matchAEv), .matchBEv(matchBEv), .ovfEv(ovfEv),
    .cmpA(cmpA), .cmpB(cmpB), .strb(strb),
    .outPin(outPin), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqOvf(irqOvf)
  );

  cmpTimerDp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(regWdata),
    .cmpA(cmpA), .cmpB(cmpB), .cntVal(cntVal),
    .matchAEv(matchAEv), .matchBEv(matchBEv), .ovfEv(ovfEv)
  );
endmodule

// File: tb/test_cmpTimer8.sv
module test_cmpTimer8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [5:0] preTaps = '0;
  logic       extClkPin = 1'b0;
  logic       rstPin = 1'b0;
  logic       trigPin = 1'b0;
  logic       outPin, irqCmpA, irqCmpB, irqOvf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpTimer8 i_cmpTimer8 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .preTaps(preTaps),
    .extClkPin(extClkPin), .rstPin(rstPin), .trigPin(trigPin),
    .outPin(outPin), .irqCmpA(irqCmpA), .irqCmpB(irqCmpB), .irqOvf(irqOvf)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic pulseTap(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); preTaps[idx] = 1'b1;
      @(negedge clk); preTaps[idx] = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic toggleExt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extClkPin = ~extClkPin;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic setPin(ref logic p, input logic v);
    @(negedge clk); p = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    rdReg(3'd0, d); check("R1 counter", d, 8'h00);
    rdReg(3'd1, d); check("R1 compare A", d, 8'hFF);
    rdReg(3'd2, d); check("R1 compare B", d, 8'hFF);
    rdReg(3'd3, d); check("R1 control 0", d, 8'h00);
    rdReg(3'd4, d); check("R1 status", d, 8'h10);
    rdReg(3'd5, d); check("R1 control 1", d, 8'hE2);
    check("R1 outputs", {4'b0, outPin, irqCmpA, irqCmpB, irqOvf}, 8'h00);
  endtask

  task automatic testStopped();
    logic [7:0] d;
    @(negedge clk); preTaps = '1;
    repeat (10) @(negedge clk);
    rdReg(3'd0, d); check("R2 field 000 stops", d, 8'h00);
    wrReg(3'd3, 8'h07);
    repeat (10) @(negedge clk);
    rdReg(3'd0, d); check("R2 field 111 stops", d, 8'h00);
    @(negedge clk); preTaps = '0;
  endtask

  task automatic testTapSelect();
    logic [7:0] d;
    wrReg(3'd3, 8'h02);
    wrReg(3'd5, 8'h01);
    @(negedge clk); preTaps = 6'b110111;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); preTaps[3] = 1'b1;
      @(negedge clk); preTaps[3] = 1'b0;
    end
    @(negedge clk); preTaps = '0;
    rdReg(3'd0, d); check("R2 strobe 3 only", d, 8'h05);
    wrReg(3'd5, 8'h00);
  endtask

  task automatic testExtClock();
    logic [7:0] d;
    wrReg(3'd3, 8'h06); wrReg(3'd0, 8'h00);
    toggleExt(4);
    rdReg(3'd0, d); check("R3 both edges", d, 8'h04);
    wrReg(3'd3, 8'h05); wrReg(3'd0, 8'h00);
    toggleExt(4);
    rdReg(3'd0, d); check("R3 falling edges", d, 8'h02);
    wrReg(3'd3, 8'h04);
    toggleExt(4);
    rdReg(3'd0, d); check("R3 rising edges", d, 8'h04);
  endtask

  task automatic testMatchA();
    logic [7:0] d;
    wrReg(3'd1, 8'h05);
    wrReg(3'd4, 8'hF2);
    wrReg(3'd3, 8'h41);
    wrReg(3'd0, 8'h00);
    pulseTap(0, 4);
    check("R4 no flag before match", {7'b0, irqCmpA}, 8'h00);
    pulseTap(0, 1);
    check("R5 irq A", {7'b0, irqCmpA}, 8'h01);
    check("R6 pin driven high", {7'b0, outPin}, 8'h01);
    rdReg(3'd4, d); check("R4 status flag A", d, 8'h52);
  endtask

  task automatic testFlagClear();
    logic [7:0] d;
    wrReg(3'd4, 8'hF2);
    wrReg(3'd4, 8'hB2);
    rdReg(3'd4, d); check("R8 unarmed write keeps flag", d & 8'h40, 8'h40);
    wrReg(3'd4, 8'hB2);
    rdReg(3'd4, d); check("R8 armed write clears flag", d & 8'h40, 8'h00);
    check("R5 irq A drops", {7'b0, irqCmpA}, 8'h00);
  endtask

  task automatic testOverflow();
    logic [7:0] d;
    wrReg(3'd3, 8'h21);
    wrReg(3'd0, 8'hFE);
    pulseTap(0, 2);
    rdReg(3'd0, d); check("R7 wrap to zero", d, 8'h00);
    rdReg(3'd4, d); check("R7 overflow flag", d & 8'h20, 8'h20);
    check("R7 overflow irq", {7'b0, irqOvf}, 8'h01);
  endtask

  task automatic testClearRestart();
    logic [7:0] d;
    wrReg(3'd2, 8'h03);
    wrReg(3'd5, 8'h08);
    wrReg(3'd3, 8'h11);
    wrReg(3'd0, 8'h00);
    pulseTap(0, 3);
    rdReg(3'd0, d); check("R9 match value visible", d, 8'h03);
    pulseTap(0, 1);
    rdReg(3'd0, d); check("R9 cleared on next count", d, 8'h00);
    pulseTap(0, 3);
    rdReg(3'd0, d); check("R10 halted ignores counts", d, 8'h00);
    setPin(trigPin, 1'b1);
    pulseTap(0, 2);
    rdReg(3'd0, d); check("R10 restart on rising trigger", d, 8'h02);
  endtask

  task automatic testPinClear();
    logic [7:0] d;
    wrReg(3'd5, 8'h00);
    wrReg(3'd3, 8'h19);
    pulseTap(0, 1);
    rdReg(3'd0, d); check("R11 counting before pin", d, 8'h03);
    setPin(rstPin, 1'b1);
    rdReg(3'd0, d); check("R11 pin clear", d, 8'h00);
    setPin(trigPin, 1'b0);
    pulseTap(0, 3);
    rdReg(3'd0, d); check("R11 code 00 never restarts", d, 8'h00);
    wrReg(3'd5, 8'h10);
    setPin(trigPin, 1'b1);
    pulseTap(0, 1);
    rdReg(3'd0, d); check("R10 rising ignored when falling selected", d, 8'h00);
    setPin(trigPin, 1'b0);
    pulseTap(0, 1);
    rdReg(3'd0, d); check("R10 restart on falling trigger", d, 8'h01);
  endtask

  task automatic testPriority();
    wrReg(3'd3, 8'h01);
    wrReg(3'd1, 8'h02);
    wrReg(3'd2, 8'h02);
    wrReg(3'd4, 8'hF6);
    wrReg(3'd0, 8'h00);
    check("R12 pin high before", {7'b0, outPin}, 8'h01);
    pulseTap(0, 2);
    check("R12 B drive-low wins", {7'b0, outPin}, 8'h00);
    wrReg(3'd1, 8'h09);
    wrReg(3'd4, 8'hFC);
    wrReg(3'd0, 8'h00);
    pulseTap(0, 2);
    check("R6 toggle on B", {7'b0, outPin}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStopped();
    testTapSelect();
    testExtClock();
    testMatchA();
    testFlagClear();
    testOverflow();
    testClearRestart();
    testPinClear();
    testPriority();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule